// File: doc/BRIEF.md
# Per-Channel DMA Credit Flow Controller

This block lives inside a multi-channel DMA engine and decides, channel by channel, when a burst to or from a peripheral FIFO may begin. The peripheral never reports its fill level. Its only feedback is a one-bit pulse per channel each time a single word leaves that channel's FIFO (memory-to-peripheral direction) or enters it (peripheral-to-memory direction). Each channel rebuilds the FIFO occupancy from these pulses and from the grants it has received. It compares that occupancy with a programmed FIFO depth and a programmed burst length. The peripheral storage is one shared pool, so each channel has its own depth. A depth set larger than the real allocation lets bursts overrun the FIFO. A depth set smaller makes the channel stall.

Each channel runs a four-state machine. CH_OFF is the disabled state, with occupancy held at zero. CH_WAIT means enabled but not enough room or data for one burst. CH_REQ means the request is raised. CH_ERR is a sticky fault. The transitions are:

- CH_OFF goes to CH_REQ or CH_WAIT when the enable is set, chosen by evaluating an empty FIFO.
- CH_WAIT and CH_REQ move between each other as the count crosses the burst threshold.
- Either CH_WAIT or CH_REQ goes to CH_ERR when an update would push the count below zero or above the depth.
- Any state goes to CH_OFF when the enable is cleared.

A round-robin arbiter picks at most one requesting channel per cycle. The granted burst is charged to that channel's count at the next clock edge.

Top module: `dma_credit_ctrl`

## Requirements
- R1: After reset, no request, no grant and no error flag is active on any channel.
- R2: A channel with direction bit 1 (memory to peripheral) requests when depth minus occupancy is at least the burst length. A grant adds the burst length to the occupancy, and each word pulse subtracts one.
- R3: A channel with direction bit 0 (peripheral to memory) requests when occupancy is at least the burst length. Each word pulse adds one, and a grant subtracts the burst length.
- R4: When a grant and a word pulse reach the same channel in the same cycle, both updates are applied together at that clock edge.
- R5: An update that would take the occupancy below zero or above the programmed depth sets that channel's error flag. The flag stays set while the channel is enabled, and in that state the request stays low and word pulses have no effect.
- R6: At most one channel is granted per cycle, and only a requesting channel. The search starts at the channel after the last one granted, so channels that keep requesting are served in turn.
- R7: Clearing a channel's enable withdraws its request at the next edge, clears its error flag and resets its occupancy to zero. Word pulses that arrive while the channel is disabled are ignored.
- R8: A channel whose burst length is programmed as zero never raises a request.
- R9: Requests are registered. A request becomes visible the cycle after the edge that made enough space or data available, and the grant appears combinationally in that same cycle.
- R10: Each channel uses its own depth and burst length, so channels with different depths receive different numbers of bursts from the same starting point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | N_CH | Per-channel enable |
| ch_to_periph | input | N_CH | Direction: 1 memory to peripheral, 0 peripheral to memory |
| ch_depth | input | N_CH*CNT_W | Programmed FIFO depth per channel, packed with channel 0 in the low bits |
| ch_burst | input | N_CH*CNT_W | Burst length per channel, packed the same way |
| word_pulse | input | N_CH | One pulse per word moved by the peripheral FIFO |
| ch_req | output | N_CH | Registered transfer request per channel |
| grant | output | N_CH | One-hot burst grant for this cycle |
| grant_valid | output | 1 | Some channel is granted this cycle |
| ch_error | output | N_CH | Sticky overflow or underflow flag per channel |

## Verification
The write direction is tried with a filling and draining sequence. This shows whether the request threshold uses free space rather than occupancy, and whether each pulse releases exactly one word. The read direction is tried with pulse trains that stop one word short of a burst and then reach it exactly, which pins down the comparison boundary. A grant arriving together with a pulse is tried in both directions, and an ordering that dropped either update would need a different number of later pulses before the request returns. Further tests drive an overflow, an underflow, pulses while disabled, a zero burst length, all channels requesting at once, and two channels with unequal depths.

// File: rtl/dma_credit_pkg.sv
`timescale 1ns/1ps
package dma_credit_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_REQ  = 2'd2,
        CH_ERR  = 2'd3
    } ch_state_e;

    localparam logic DIR_TO_PERIPH = 1'b1;

endpackage

// File: rtl/credit_channel.sv
`timescale 1ns/1ps
module credit_channel
    import dma_credit_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             to_periph,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] burst,
    input  logic             pulse,
    input  logic             granted,
    output logic             req,
    output logic             err
);

    localparam int SUM_W = CNT_W + 2;

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic signed [SUM_W-1:0] cnt_s, depth_s, burst_s, step_up, step_dn, sum_s;
    logic                    take;

    // Readiness of a candidate occupancy value for one burst
    function automatic logic burst_ready(input logic signed [SUM_W-1:0] occ,
                                         input logic signed [SUM_W-1:0] dep,
                                         input logic signed [SUM_W-1:0] bl,
                                         input logic                    wr);
        logic ok;
        if (bl == '0) begin
            ok = 1'b0;
        end else if (wr == DIR_TO_PERIPH) begin
            ok = (dep - occ) >= bl;
        end else begin
            ok = occ >= bl;
        end
        return ok;
    endfunction

    always_comb begin
        cnt_s   = $signed({2'b00, cnt_q});
        depth_s = $signed({2'b00, depth});
        burst_s = $signed({2'b00, burst});
        take    = granted && (state_q == CH_REQ);
        if (to_periph == DIR_TO_PERIPH) begin
            step_up = take  ? burst_s : '0;
            step_dn = pulse ? SUM_W'(1) : '0;
        end else begin
            step_up = pulse ? SUM_W'(1) : '0;
            step_dn = take  ? burst_s : '0;
        end
        sum_s = cnt_s + step_up - step_dn;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_OFF: begin
                cnt_d = '0;
                if (en) begin
                    state_d = burst_ready('0, depth_s, burst_s, to_periph) ? CH_REQ : CH_WAIT;
                end
            end
            CH_WAIT, CH_REQ: begin
                if (sum_s < 0 || sum_s > depth_s) begin
                    state_d = CH_ERR;
                end else begin
                    cnt_d   = sum_s[CNT_W-1:0];
                    state_d = burst_ready(sum_s, depth_s, burst_s, to_periph) ? CH_REQ : CH_WAIT;
                end
            end
            CH_ERR: begin
                state_d = CH_ERR;
            end
            default: begin
                state_d = CH_OFF;
            end
        endcase
        if (!en) begin
            state_d = CH_OFF;
            cnt_d   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        req = 1'b0;
        err = 1'b0;
        unique case (state_q)
            CH_REQ:  req = 1'b1;
            CH_ERR:  err = 1'b1;
            default: ;
        endcase
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> (state_q == CH_REQ)) else $error("grant without request"); // R6

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ERR && en) |=> (state_q == CH_ERR)) else $error("error flag lost"); // R5

    AST_DISABLE_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == CH_OFF && cnt_q == '0)) else $error("disable not honoured"); // R7

endmodule

// File: rtl/rr_arbiter.sv
`timescale 1ns/1ps
module rr_arbiter #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req,
    output logic [N_CH-1:0] grant,
    output logic            grant_valid
);

    localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win;

    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        win         = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (!grant_valid && req[(int'(ptr_q) + k) % N_CH]) begin
                grant_valid = 1'b1;
                win         = IDX_W'((int'(ptr_q) + k) % N_CH);
            end
        end
        if (grant_valid) begin
            grant[win] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (grant_valid) begin
            ptr_q <= (int'(win) == N_CH - 1) ? '0 : win + IDX_W'(1);
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("multiple grants"); // R6

    AST_VALID_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> grant_valid) else $error("request left unserved"); // R6

endmodule

// File: rtl/dma_credit_ctrl.sv
`timescale 1ns/1ps
module dma_credit_ctrl #(
    parameter int N_CH      = 4,
    parameter int MAX_DEPTH = 64,
    localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       ch_enable,
    input  logic [N_CH-1:0]       ch_to_periph,
    input  logic [N_CH*CNT_W-1:0] ch_depth,
    input  logic [N_CH*CNT_W-1:0] ch_burst,
    input  logic [N_CH-1:0]       word_pulse,
    output logic [N_CH-1:0]       ch_req,
    output logic [N_CH-1:0]       grant,
    output logic                  grant_valid,
    output logic [N_CH-1:0]       ch_error
);

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        credit_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_enable[g]),
            .to_periph (ch_to_periph[g]),
            .depth     (ch_depth[g*CNT_W +: CNT_W]),
            .burst     (ch_burst[g*CNT_W +: CNT_W]),
            .pulse     (word_pulse[g]),
            .granted   (grant[g]),
            .req       (ch_req[g]),
            .err       (ch_error[g])
        );
    end

    rr_arbiter #(
        .N_CH (N_CH)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (ch_req),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

endmodule

// File: tb/dma_credit_ctrl_bench.sv
`timescale 1ns/1ps
module dma_credit_ctrl_bench;

    localparam int N  = 4;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ch_enable = '0;
    logic [N-1:0]  ch_to_periph = '0;
    logic [N*CW-1:0] ch_depth = '0;
    logic [N*CW-1:0] ch_burst = '0;
    logic [N-1:0]  word_pulse = '0;
    logic [N-1:0]  ch_req, grant, ch_error;
    logic          grant_valid;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dma_credit_ctrl #(.N_CH(N), .MAX_DEPTH(64)) u_dma_credit_ctrl (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_to_periph(ch_to_periph),
        .ch_depth(ch_depth), .ch_burst(ch_burst), .word_pulse(word_pulse),
        .ch_req(ch_req), .grant(grant), .grant_valid(grant_valid), .ch_error(ch_error)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input logic wr, input int dep, input int bl);
        ch_to_periph[ch] = wr;
        ch_depth[ch*CW +: CW] = CW'(dep);
        ch_burst[ch*CW +: CW] = CW'(bl);
    endtask

    // one clock edge consuming pulse vector p; returns at next negedge
    task automatic step(input logic [N-1:0] p);
        word_pulse = p;
        @(negedge clk);
        word_pulse = '0;
    endtask

    task automatic t_reset;
        check("R1 req", int'(ch_req), 0);
        check("R1 grant", int'(grant), 0);
        check("R1 error", int'(ch_error), 0);
    endtask

    task automatic t_write;
        cfg(0, 1'b1, 8, 4);
        ch_enable = 4'b0001;
        step('0);
        check("R9 R2 req after enable", int'(ch_req[0]), 1);
        check("R2 grant", int'(grant), 1);
        step('0);
        check("R2 still room", int'(ch_req[0]), 1);
        step('0);
        check("R2 full no req", int'(ch_req[0]), 0);
        for (int i = 0; i < 3; i++) begin
            step(4'b0001);
            check("R2 below threshold", int'(ch_req[0]), 0);
        end
        step(4'b0001);
        check("R2 fourth pulse frees burst", int'(ch_req[0]), 1);
        step(4'b0001);           // grant and pulse together -> 7
        check("R4 write after joint update", int'(ch_req[0]), 0);
        step(4'b0001);
        step(4'b0001);
        check("R4 write two pulses short", int'(ch_req[0]), 0);
        step(4'b0001);
        check("R4 write third pulse frees", int'(ch_req[0]), 1);
        ch_enable = '0;
        step('0);
        check("R7 disable withdraws", int'(ch_req[0]), 0);
    endtask

    task automatic t_read;
        cfg(1, 1'b0, 8, 3);
        ch_enable = 4'b0010;
        step('0);
        check("R3 empty no req", int'(ch_req[1]), 0);
        step(4'b0010);
        step(4'b0010);
        check("R3 two words short", int'(ch_req[1]), 0);
        step(4'b0010);
        check("R3 burst available", int'(ch_req[1]), 1);
        check("R3 grant", int'(grant), 2);
        step(4'b0010);           // 3+1-3 = 1
        check("R4 read after joint update", int'(ch_req[1]), 0);
        step(4'b0010);
        check("R4 read one short", int'(ch_req[1]), 0);
        step(4'b0010);
        check("R4 read reaches burst", int'(ch_req[1]), 1);
        ch_enable = '0;
        step('0);
    endtask

    task automatic t_error;
        cfg(2, 1'b0, 4, 0);
        ch_enable = 4'b0100;
        step('0);
        for (int i = 0; i < 4; i++) begin
            step(4'b0100);
            check("R8 zero burst no req", int'(ch_req[2]), 0);
        end
        check("R5 at depth no error", int'(ch_error[2]), 0);
        step(4'b0100);
        check("R5 overflow flagged", int'(ch_error[2]), 1);
        cfg(2, 1'b0, 4, 2);
        step(4'b0100);
        step(4'b0100);
        check("R5 error sticky", int'(ch_error[2]), 1);
        check("R5 no req in error", int'(ch_req[2]), 0);
        ch_enable = '0;
        step('0);
        check("R7 error cleared", int'(ch_error[2]), 0);
        ch_enable = 4'b0100;
        step('0);
        check("R7 count reset", int'(ch_req[2]), 0);
        step(4'b0100);
        step(4'b0100);
        check("R7 counts from zero", int'(ch_req[2]), 1);
        ch_enable = '0;
        step('0);
        for (int i = 0; i < 3; i++) step(4'b0100);
        ch_enable = 4'b0100;
        step('0);
        check("R7 pulses while off ignored", int'(ch_req[2]), 0);
        ch_enable = '0;
        step('0);
        cfg(3, 1'b1, 4, 0);
        ch_enable = 4'b1000;
        step('0);
        step(4'b1000);
        check("R5 underflow flagged", int'(ch_error[3]), 1);
        ch_enable = '0;
        step('0);
    endtask

    task automatic t_round_robin;
        int cnt [N];
        logic [N-1:0] last;
        for (int c = 0; c < N; c++) begin
            cfg(c, 1'b1, 16, 4);
            cnt[c] = 0;
        end
        ch_enable = '1;
        step('0);
        last = '0;
        for (int s = 0; s < 8; s++) begin
            check("R6 one grant", $countones(grant), 1);
            check("R6 no repeat", int'((grant & last) != 0), 0);
            for (int c = 0; c < N; c++) if (grant[c]) cnt[c]++;
            last = grant;
            step('0);
        end
        for (int c = 0; c < N; c++) check("R6 fair share", cnt[c], 2);
        ch_enable = '0;
        step('0);
    endtask

    task automatic t_sizes;
        int g0 = 0;
        int g1 = 0;
        cfg(0, 1'b1, 4, 4);
        cfg(1, 1'b1, 12, 4);
        ch_enable = 4'b0011;
        step('0);
        for (int s = 0; s < 6; s++) begin
            if (grant[0]) g0++;
            if (grant[1]) g1++;
            step('0);
        end
        check("R10 small depth bursts", g0, 1);
        check("R10 large depth bursts", g1, 3);
        check("R10 both full", int'(ch_req[1:0]), 0);
        ch_enable = '0;
        step('0);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write;
        t_read;
        t_error;
        t_round_robin;
        t_sizes;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule